// File: doc/BRIEF.md
# Write-Only Tuner Control Bus Slave

This block receives write transfers on a two-wire serial bus (I2C, standard slave-receiver role) and turns them into the settings of a frequency-synthesizer front end. SCL and SDA are oversampled by the system clock, so the block needs no clock from the bus. It recognises start and stop conditions, takes the address byte and compares it with its own 7-bit address. The upper five address bits are fixed; the two low bits come from a strap input, so up to four of these slaves can share one bus. It acknowledges the address and every data byte that follows.

Data bytes arrive in pairs. The leading bit of the first byte of a pair selects its meaning. A 0 makes the pair a 15-bit divider ratio. A 1 makes it a pair of control bytes: charge-pump test and current settings, a tuning-amplifier disable, two band-select outputs and a general output. One telegram may carry several pairs. Outputs change only when a pair is complete, and a one-cycle load strobe marks each update. The outputs are plain level signals with no handshake. The block has no data stream of its own and so no back-pressure: the bus master sets the pace. SDA is driven open-drain through a single pull-low enable.

Top module: `tuner_i2c_slave`

## Requirements
- R1: After reset the divider ratio is 0, every control and band output is 0, sda_oe is 0 and load_stb is 0.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Bits are taken on SCL rising edges, most significant bit first.
- R3: An address byte equal to {5'b11000, addr_strap, 1'b0} is acknowledged: SDA is held low for the whole high phase of the ninth SCL clock. Every later data byte of that telegram is acknowledged the same way.
- R4: An address byte whose upper seven bits differ from {5'b11000, addr_strap}, or whose last bit is 1 (read), gets no acknowledge. The slave then leaves SDA released and changes no output until the next start.
- R5: In a pair whose first byte has bit 7 = 0, div_ratio becomes {first[6:0], second[7:0]}.
- R6: In a pair whose first byte has bit 7 = 1, the first byte sets pump_hi = bit 6, test_cy = bit 5, test_hiz = bit 4 and tune_off = bit 0. The second byte sets gp_out = bit 7, band_b = bit 1 and band_a = bit 0.
- R7: Outputs change only after the second byte of a pair has been taken. Each completed pair gives exactly one load_stb pulse, one clock long.
- R8: A stop or a start that follows only the first byte of a pair discards that byte: no output changes and no load_stb occurs.
- R9: The third data byte of a telegram begins a new pair, and its own bit 7 selects that pair's meaning.
- R10: sda_oe is the only SDA drive and it pulls low. It changes only while SCL is low and is released after every start or stop.
- R11: If SDA and SCL change in the same system-clock sample, no start or stop is seen. A data bit that changes on the same edge as the SCL fall is taken normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| addr_strap | input | 2 | Low two bits of the slave address |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| div_ratio | output | 15 | Programmed divider ratio |
| test_hiz | output | 1 | Charge pump forced high-impedance |
| test_cy | output | 1 | Divided test signal routed to the general output |
| pump_hi | output | 1 | High charge-pump current selected |
| tune_off | output | 1 | Tuning-voltage amplifier disabled |
| band_a | output | 1 | Band-select output A |
| band_b | output | 1 | Band-select output B |
| gp_out | output | 1 | General-purpose output |
| load_stb | output | 1 | One-cycle pulse when a pair is loaded |

## Verification
Two things can happen on the same system-clock edge: the master moves SDA to the next data bit, and SCL falls. The receiver must treat this as a normal data change and not as a start or a stop. The bench provokes it on every bit by driving SDA and SCL in the same time step. A bit misread as a bus event would break the transfer, so this is judged by the acknowledges and by the register values that follow. The other pair is the release of the acknowledge, which happens on the falling edge where the master sets its next bit. The wired-AND line model checks that bytes run back to back across that edge: four bytes in one telegram must load both pairs.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;
  localparam int DIV_W      = 15;
  localparam int BYTE_W     = 8;
  localparam int STRAP_W    = 2;
  localparam int ADDR_W     = 7;
  localparam int FIXED_W    = ADDR_W - STRAP_W;
  localparam logic [FIXED_W-1:0] ADDR_FIXED = 5'b11000;

  localparam int SEL_BIT     = 7;
  localparam int PUMP_BIT    = 6;
  localparam int CY_BIT      = 5;
  localparam int HIZ_BIT     = 4;
  localparam int TOFF_BIT    = 0;
  localparam int GP_BIT      = 7;
  localparam int BAND_B_BIT  = 1;
  localparam int BAND_A_BIT  = 0;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_BITS,
    RX_HOLD,
    RX_ACK,
    RX_IGNORE
  } rx_state_t;

  typedef struct packed {
    logic pump_hi;
    logic test_cy;
    logic test_hiz;
    logic tune_off;
    logic gp_out;
    logic band_b;
    logic band_a;
  } ctl_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [SYNC_STAGES-1:0] scl_sh;
  logic [SYNC_STAGES-1:0] sda_sh;
  logic scl_p, sda_p;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_sh[0] <= 1'b1;
            sda_sh[0] <= 1'b1;
          end else begin
            scl_sh[0] <= scl_i;
            sda_sh[0] <= sda_i;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_sh[g] <= 1'b1;
            sda_sh[g] <= 1'b1;
          end else begin
            scl_sh[g] <= scl_sh[g-1];
            sda_sh[g] <= sda_sh[g-1];
          end
        end
      end
    end
  endgenerate

  assign scl_q = scl_sh[SYNC_STAGES-1];
  assign sda_q = sda_sh[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_q;
      sda_p <= sda_q;
    end
  end

  // SCL must be high in both samples, so a simultaneous change is no event
  assign scl_rise  = scl_q & ~scl_p;
  assign scl_fall  = ~scl_q & scl_p;
  assign start_evt = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_evt  = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/i2c_byte_rx.sv
module i2c_byte_rx
  import tuner_i2c_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sda_q,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_evt,
  input  logic               stop_evt,
  input  logic [STRAP_W-1:0] addr_strap,
  output logic               sda_oe,
  output logic               byte_stb,
  output logic [BYTE_W-1:0]  byte_data
);
  localparam int CNT_W = $clog2(BYTE_W);

  rx_state_t          state;
  logic [CNT_W-1:0]   bit_cnt;
  logic [BYTE_W-1:0]  shreg;
  logic               is_addr;
  logic               ack_hi;
  logic [BYTE_W-1:0]  next_byte;
  logic               addr_ok;

  assign next_byte = {shreg[BYTE_W-2:0], sda_q};
  assign addr_ok   = (next_byte[BYTE_W-1:1] == {ADDR_FIXED, addr_strap}) &&
                     (next_byte[0] == 1'b0);
  assign byte_data = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      is_addr  <= 1'b0;
      ack_hi   <= 1'b0;
      sda_oe   <= 1'b0;
      byte_stb <= 1'b0;
    end else begin
      byte_stb <= 1'b0;
      if (stop_evt) begin
        state  <= RX_IDLE;
        sda_oe <= 1'b0;
      end else if (start_evt) begin
        state   <= RX_BITS;
        is_addr <= 1'b1;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else begin
        unique case (state)
          RX_BITS: if (scl_rise) begin
            shreg <= next_byte;
            if (bit_cnt == CNT_W'(BYTE_W-1)) begin
              bit_cnt <= '0;
              if (!is_addr || addr_ok) state <= RX_HOLD;
              else                     state <= RX_IGNORE;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          RX_HOLD: if (scl_fall) begin
            sda_oe <= 1'b1;
            ack_hi <= 1'b0;
            state  <= RX_ACK;
          end
          RX_ACK: begin
            if (scl_rise) begin
              ack_hi <= 1'b1;
              if (!is_addr) byte_stb <= 1'b1;
            end
            if (scl_fall && ack_hi) begin
              sda_oe  <= 1'b0;
              ack_hi  <= 1'b0;
              is_addr <= 1'b0;
              state   <= RX_BITS;
            end
          end
          RX_IDLE, RX_IGNORE: ;
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/tuner_ctl_regs.sv
module tuner_ctl_regs
  import tuner_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_evt,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_data,
  output logic [DIV_W-1:0]  div_ratio,
  output ctl_t              ctl,
  output logic              load_stb
);
  localparam int HI_W = DIV_W - BYTE_W;

  logic              have_first;
  logic [BYTE_W-1:0] first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_first <= 1'b0;
      first_q    <= '0;
      div_ratio  <= '0;
      ctl        <= '0;
      load_stb   <= 1'b0;
    end else begin
      load_stb <= 1'b0;
      if (bus_evt) begin
        have_first <= 1'b0;
      end else if (byte_stb) begin
        if (!have_first) begin
          first_q    <= byte_data;
          have_first <= 1'b1;
        end else begin
          have_first <= 1'b0;
          load_stb   <= 1'b1;
          if (first_q[SEL_BIT]) begin
            ctl.pump_hi  <= first_q[PUMP_BIT];
            ctl.test_cy  <= first_q[CY_BIT];
            ctl.test_hiz <= first_q[HIZ_BIT];
            ctl.tune_off <= first_q[TOFF_BIT];
            ctl.gp_out   <= byte_data[GP_BIT];
            ctl.band_b   <= byte_data[BAND_B_BIT];
            ctl.band_a   <= byte_data[BAND_A_BIT];
          end else begin
            div_ratio <= {first_q[HI_W-1:0], byte_data};
          end
        end
      end
    end
  end
endmodule

// File: rtl/tuner_i2c_slave.sv
module tuner_i2c_slave
  import tuner_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] addr_strap,
  output logic               sda_oe,
  output logic [DIV_W-1:0]   div_ratio,
  output logic               test_hiz,
  output logic               test_cy,
  output logic               pump_hi,
  output logic               tune_off,
  output logic               band_a,
  output logic               band_b,
  output logic               gp_out,
  output logic               load_stb
);
  logic scl_q, sda_q, scl_rise, scl_fall, start_evt, stop_evt;
  logic byte_stb;
  logic [BYTE_W-1:0] byte_data;
  ctl_t ctl;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_byte_rx u_rx (
    .clk(clk), .rst_n(rst_n), .sda_q(sda_q), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .addr_strap(addr_strap), .sda_oe(sda_oe), .byte_stb(byte_stb),
    .byte_data(byte_data)
  );

  tuner_ctl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_evt(start_evt | stop_evt),
    .byte_stb(byte_stb), .byte_data(byte_data), .div_ratio(div_ratio),
    .ctl(ctl), .load_stb(load_stb)
  );

  assign test_hiz = ctl.test_hiz;
  assign test_cy  = ctl.test_cy;
  assign pump_hi  = ctl.pump_hi;
  assign tune_off = ctl.tune_off;
  assign band_a   = ctl.band_a;
  assign band_b   = ctl.band_b;
  assign gp_out   = ctl.gp_out;
endmodule

// File: rtl/tuner_i2c_checker.sv
module tuner_i2c_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_q,
  input logic        bus_evt,
  input logic        sda_oe,
  input logic        load_stb,
  input logic [14:0] div_ratio,
  input logic [6:0]  ctl_bits
);
  // R7: a load pulse lasts one clock
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb);

  // R7: divider only moves together with a load pulse
  a_r7_div_with_load: assert property (@(posedge clk) disable iff (!rst_n)
    (div_ratio != $past(div_ratio)) |-> load_stb);

  // R7: control bits only move together with a load pulse
  a_r7_ctl_with_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_bits != $past(ctl_bits)) |-> load_stb);

  // R10: the SDA drive changes only while SCL is low
  a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_q));

  // R10: released after any start or stop
  a_r10_release_on_evt: assert property (@(posedge clk) disable iff (!rst_n)
    bus_evt |=> !sda_oe);

  // R8: no load follows a start or stop directly
  a_r8_no_load_after_evt: assert property (@(posedge clk) disable iff (!rst_n)
    bus_evt |=> !load_stb);
endmodule

bind tuner_i2c_slave tuner_i2c_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .bus_evt(start_evt | stop_evt),
  .sda_oe(sda_oe), .load_stb(load_stb), .div_ratio(div_ratio),
  .ctl_bits({pump_hi, test_cy, test_hiz, tune_off, gp_out, band_b, band_a})
);

// File: tb/tuner_i2c_slave_tb_top.sv
module tuner_i2c_slave_tb_top;
  localparam int H = 20;
  localparam int NV = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] strap = 2'd0;
  logic sda_oe, load_stb;
  logic [14:0] div_ratio;
  logic test_hiz, test_cy, pump_hi, tune_off, band_a, band_b, gp_out;
  logic sda_line;
  logic [6:0] ctl_w;

  int n_chk = 0, n_bad = 0, loads = 0, oe_cyc = 0;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;
  assign ctl_w = {pump_hi, test_cy, test_hiz, tune_off, gp_out, band_b, band_a};

  tuner_i2c_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_strap(strap), .sda_oe(sda_oe), .div_ratio(div_ratio),
    .test_hiz(test_hiz), .test_cy(test_cy), .pump_hi(pump_hi),
    .tune_off(tune_off), .band_a(band_a), .band_b(band_b), .gp_out(gp_out),
    .load_stb(load_stb)
  );

  always @(negedge clk) begin
    if (load_stb) loads++;
    if (sda_oe) oe_cyc++;
  end

  // {strap, addr, byte1, byte2, ack, div, ctl, load}
  localparam logic [49:0] VEC [0:NV-1] = '{
    {2'd0, 8'hC0, 8'h12, 8'h34, 1'b1, 15'h1234, 7'b0000000, 1'b1},
    {2'd0, 8'hC0, 8'hD1, 8'h83, 1'b1, 15'h1234, 7'b1011111, 1'b1},
    {2'd2, 8'hC4, 8'h7F, 8'hFF, 1'b1, 15'h7FFF, 7'b1011111, 1'b1},
    {2'd2, 8'hC2, 8'h01, 8'h02, 1'b0, 15'h7FFF, 7'b1011111, 1'b0},
    {2'd3, 8'hC6, 8'h00, 8'h00, 1'b1, 15'h0000, 7'b1011111, 1'b1},
    {2'd3, 8'hC7, 8'h12, 8'h34, 1'b0, 15'h0000, 7'b1011111, 1'b0},
    {2'd1, 8'hC2, 8'hA0, 8'h02, 1'b1, 15'h0000, 7'b0100010, 1'b1}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(H);
    scl_m = 1'b1; wait_clk(H);
    sda_m = 1'b0; wait_clk(H);
    scl_m = 1'b0; wait_clk(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(H);
    scl_m = 1'b1; wait_clk(H);
    sda_m = 1'b1; wait_clk(H);
  endtask

  // SDA is changed in the same step as the SCL fall (R11 corner)
  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_clk(H);
      scl_m = 1'b1; wait_clk(H);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; wait_clk(H);
    scl_m = 1'b1; wait_clk(H / 2);
    acked = ~sda_line;
    wait_clk(H / 2);
    scl_m = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic a0, a1, a2, a3;
    int l0, o0;
    wait_clk(3);
    // R1 reset state
    check("R1 div", int'(div_ratio), 0);
    check("R1 ctl", int'(ctl_w), 0);
    check("R1 oe", int'(sda_oe), 0);
    check("R1 load", int'(load_stb), 0);
    rst_n = 1'b1;
    wait_clk(5);

    for (int v = 0; v < NV; v++) begin
      logic [49:0] e;
      e = VEC[v];
      strap = e[49:48];
      wait_clk(5);
      l0 = loads;
      bus_start();
      send_byte(e[47:40], a0);
      send_byte(e[39:32], a1);
      send_byte(e[31:24], a2);
      bus_stop();
      wait_clk(5);
      check($sformatf("R3 R4 addr ack v%0d", v), int'(a0), int'(e[23]));
      check($sformatf("R3 data ack v%0d", v), int'(a2), int'(e[23]));
      check($sformatf("R5 R2 div v%0d", v), int'(div_ratio), int'(e[22:8]));
      check($sformatf("R6 ctl v%0d", v), int'(ctl_w), int'(e[7:1]));
      check($sformatf("R7 loads v%0d", v), loads - l0, int'(e[0]));
    end

    // R8: half pair then stop is dropped
    l0 = loads;
    bus_start(); send_byte(8'hC2, a0); send_byte(8'h05, a1); bus_stop();
    wait_clk(5);
    check("R8 stop div", int'(div_ratio), 0);
    check("R8 stop loads", loads - l0, 0);

    // R8: repeated start after one byte, then a full divider pair
    l0 = loads;
    bus_start(); send_byte(8'hC2, a0); send_byte(8'h11, a1);
    bus_start(); send_byte(8'hC2, a0); send_byte(8'h22, a1); send_byte(8'h33, a2);
    bus_stop();
    wait_clk(5);
    check("R8 rstart div", int'(div_ratio), 'h2233);
    check("R8 rstart loads", loads - l0, 1);

    // R9 and R11: divider pair then control pair in one telegram
    l0 = loads;
    bus_start(); send_byte(8'hC2, a0); send_byte(8'h01, a1); send_byte(8'h02, a2);
    send_byte(8'hC0, a3); send_byte(8'h01, a1);
    bus_stop();
    wait_clk(5);
    check("R9 div", int'(div_ratio), 'h0102);
    check("R9 ctl", int'(ctl_w), 'b1000001);
    check("R9 loads", loads - l0, 2);
    check("R11 byte3 ack", int'(a3), 1);

    // R4 and R10: wrong address, slave stays off the line
    l0 = loads; o0 = oe_cyc;
    bus_start(); send_byte(8'hC0, a0); send_byte(8'h55, a1); send_byte(8'h66, a2);
    bus_stop();
    wait_clk(5);
    check("R4 nack addr", int'(a0), 0);
    check("R4 nack data", int'(a1), 0);
    check("R10 no drive", oe_cyc - o0, 0);
    check("R4 div kept", int'(div_ratio), 'h0102);
    check("R4 loads", loads - l0, 0);
    check("R10 oe idle", int'(sda_oe), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule